// File: doc/BRIEF.md
# Self-Framing Serial Segment Latch Driver

This block receives display data over a slow two-wire serial link (a data line and a serial clock), gated by a data-enable input. It drives a bank of parallel segment outputs directly, with no multiplexing. No load or select line exists. Each frame begins with a single start bit of value one. The start bit is followed by one payload bit for each output. The frame boundary is found when that start bit reaches the far end of an internal shift chain that has one stage more than there are outputs.

The serial inputs pass through a synchroniser into a fast system clock. A rising serial-clock edge shifts the sampled data into the chain. When a shift brings the start bit to the last stage, a one-cycle load strobe copies the payload into the output latches. The next falling serial-clock edge then empties the chain for the following frame. A frame that is cut short loads nothing. Its bits stay in the chain and the outputs keep their values. The sampled data input is never cleared, so a new frame can follow the previous one with no gap.

Top module: `seg_latch_drv`

## Requirements
- R1: While `rst_n` is low, all shift stages and all `seg_o` bits clear at the next system-clock edge, and `load_o` is low.
- R2: After a start bit of 1 followed by NUM_OUT payload bits, payload bit k (k = 1 is the first bit after the start bit) appears on `seg_o[k-1]`.
- R3: `load_o` pulses high for exactly one system cycle per completed frame, in the cycle the start bit reaches the last chain stage.
- R4: A frame with fewer than NUM_OUT+1 enabled serial clocks produces no `load_o` pulse and leaves `seg_o` unchanged.
- R5: The enabled falling serial-clock edge that follows a load empties the whole chain. A frame sent straight after it loads correctly.
- R6: Serial-clock edges seen while `ser_en_i` is low neither shift nor clear the chain, and a frame split by such a pause loads only its enabled bits.
- R7: Zero bits clocked before a start bit are ignored, and the frame that follows loads normally.
- R8: `seg_o` changes only in the cycle after a `load_o` pulse. Reloading identical data leaves every output unchanged.
- R9: A reset in the middle of a frame discards the partial frame, and the next complete frame loads normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous to `clk` |
| ser_dat_i | input | 1 | Serial data, sampled on serial-clock rising edges |
| ser_en_i | input | 1 | Data enable; serial-clock edges are ignored while low |
| seg_o | output | NUM_OUT | Latched segment outputs, bit k-1 holds payload bit k |
| load_o | output | 1 | One-cycle strobe on each frame load |

## Verification
The bench builds the block with its default values: 35 outputs and a two-stage synchroniser. A start bit therefore needs a full 36 enabled clocks to reach the chain end, which exercises the exact frame length. The serial clock's half period is six system cycles. This brings partial frames, enable pauses in the middle of a frame, back-to-back frames and resets in the middle of a frame within reach of a behavioural queue model. That model is compared against the outputs every settled cycle.

// File: rtl/sld_pkg.sv
`timescale 1ns/1ps
// Package: types shared by the serial segment latch driver.
// Assumes: one event of each kind at most per system cycle.
package sld_pkg;
    // Qualified serial-clock edge events, already gated by data-enable.
    typedef struct packed {
        logic rise;
        logic fall;
    } sld_evt_t;
endpackage

// File: rtl/sld_sync.sv
`timescale 1ns/1ps
// Module: multi-bit synchroniser, one flop chain per input bit.
// Assumes: each bit is independently slow compared to clk; no bus coherence needed
// beyond the setup margin the sender provides.
module sld_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0] pipe_q [WIDTH];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        // Shift the raw level through STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe_q[b] <= '0;
            else        pipe_q[b] <= {pipe_q[b][STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = pipe_q[b][STAGES-1];
    end
endmodule

// File: rtl/sld_edge.sv
`timescale 1ns/1ps
// Module: serial-clock edge detector with enable qualification.
// Assumes: inputs already synchronised to clk; serial clock slower than clk/4.
module sld_edge
    import sld_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sclk_s,
    input  logic     en_s,
    output sld_evt_t evt_o
);
    logic sclk_prev_q;

    // Remember last sampled serial-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    // Produce enabled rise and fall events.
    always_comb begin
        evt_o.rise = en_s &  sclk_s & ~sclk_prev_q;
        evt_o.fall = en_s & ~sclk_s &  sclk_prev_q;
    end
endmodule

// File: rtl/sld_chain.sv
`timescale 1ns/1ps
// Module: self-framing shift chain of NUM_OUT+1 stages.
// A rise event shifts sampled data in at stage 0; when the shift lands a 1 in the
// last stage a one-cycle load strobe is raised. A fall event with a 1 in the last
// stage empties the whole chain. Assumes rise and fall never coincide.
module sld_chain
    import sld_pkg::*;
#(
    parameter int NUM_OUT = 35
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sld_evt_t           evt_i,
    input  logic               dat_s,
    output logic [NUM_OUT:0]   chain_o,
    output logic               load_o
);
    localparam int LAST = NUM_OUT;

    logic [LAST:0] stage_q;
    logic          load_q;

    // Shift on rise, clear a completed frame on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            load_q  <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (evt_i.rise) begin
                stage_q <= {stage_q[LAST-1:0], dat_s};
                load_q  <= stage_q[LAST-1];
            end else if (evt_i.fall && stage_q[LAST]) begin
                stage_q <= '0;
            end
        end
    end

    assign chain_o = stage_q;
    assign load_o  = load_q;
endmodule

// File: rtl/sld_latch.sv
`timescale 1ns/1ps
// Module: output latch bank. Payload bit k (first after start) sits in chain
// stage NUM_OUT-k and goes to output k-1.
// Assumes: load strobe is one cycle wide and chain is stable while it is high.
module sld_latch #(
    parameter int NUM_OUT = 35
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [NUM_OUT:0]   chain_i,
    output logic [NUM_OUT-1:0] seg_o
);
    logic [NUM_OUT-1:0] payload;
    logic [NUM_OUT-1:0] seg_q;

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_map
        assign payload[j] = chain_i[NUM_OUT-1-j];
    end

    // Capture payload on load, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      seg_q <= '0;
        else if (load_i) seg_q <= payload;
    end

    assign seg_o = seg_q;
endmodule

// File: rtl/seg_latch_drv.sv
`timescale 1ns/1ps
// Module: top of the self-framing serial segment latch driver.
// Assumes: serial clock at most a small fraction of clk; data and enable are set
// up at least one serial half period before the serial-clock edge that uses them.
module seg_latch_drv
    import sld_pkg::*;
#(
    parameter int NUM_OUT     = 35,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_clk_i,
    input  logic               ser_dat_i,
    input  logic               ser_en_i,
    output logic [NUM_OUT-1:0] seg_o,
    output logic               load_o
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] raw;
    logic [NSYNC-1:0] syn;
    sld_evt_t         evt;
    logic [NUM_OUT:0] chain_q;
    logic             load;

    assign raw = {ser_en_i, ser_dat_i, ser_clk_i};

    sld_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(syn)
    );

    sld_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk_s(syn[0]), .en_s(syn[2]), .evt_o(evt)
    );

    sld_chain #(.NUM_OUT(NUM_OUT)) u_chain (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .dat_s(syn[1]),
        .chain_o(chain_q), .load_o(load)
    );

    sld_latch #(.NUM_OUT(NUM_OUT)) u_latch (
        .clk(clk), .rst_n(rst_n), .load_i(load), .chain_i(chain_q), .seg_o(seg_o)
    );

    assign load_o = load;
endmodule

// File: rtl/sld_chk.sv
`timescale 1ns/1ps
// Module: property checker for seg_latch_drv, attached by bind.
module sld_chk #(
    parameter int NUM_OUT = 35
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_o,
    input logic [NUM_OUT-1:0] seg_o,
    input logic               rise_evt,
    input logic               fall_evt,
    input logic [NUM_OUT:0]   chain_q
);
    // R1
    rst_state_chk: assert property (@(posedge clk) !rst_n |=> (seg_o == '0 && !load_o));

    // R3
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n) load_o |=> !load_o);

    // R2
    load_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n) load_o |-> chain_q[NUM_OUT]);

    // R8
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !load_o |=> $stable(seg_o));

    // R5
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_evt && chain_q[NUM_OUT]) |=> (chain_q == '0));

    // R6
    chain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_evt && !fall_evt) |=> $stable(chain_q));
endmodule

bind seg_latch_drv sld_chk #(.NUM_OUT(NUM_OUT)) u_sld_chk (
    .clk(clk), .rst_n(rst_n), .load_o(load_o), .seg_o(seg_o),
    .rise_evt(evt.rise), .fall_evt(evt.fall), .chain_q(chain_q)
);

// File: tb/test_seg_latch_drv.sv
`timescale 1ns/1ps
// Bench: behavioural queue model compared against the outputs on every settled clock.
module test_seg_latch_drv;
    localparam int CLK_PERIOD = 10;
    localparam int NOUT       = 35;
    localparam int HALF       = 6;
    localparam int SETTLE     = 6;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sdat = 1'b0;
    logic sen = 1'b0;
    logic [NOUT-1:0] seg;
    logic            load;

    seg_latch_drv #(.NUM_OUT(NOUT), .SYNC_STAGES(2)) i_seg_latch_drv (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
        .ser_en_i(sen), .seg_o(seg), .load_o(load)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;
    int settle = 0;
    int cycles = 0;
    int load_seen = 0;
    int load_exp = 0;
    bit q[$];
    logic [NOUT-1:0] exp_seg = '0;
    string req = "R1";

    task automatic chk(input bit ok, input string what,
                       input logic [NOUT-1:0] act, input logic [NOUT-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    function automatic void model_rise(bit d);
        if (sen) begin
            q.push_back(d);
            if (q.size() > NOUT + 1) void'(q.pop_front());
            if (q.size() == NOUT + 1 && q[0]) begin
                for (int j = 0; j < NOUT; j++) exp_seg[j] = q[j+1];
                load_exp++;
            end
        end
    endfunction

    function automatic void model_fall();
        if (sen && q.size() == NOUT + 1 && q[0]) q.delete();
    endfunction

    // Per-cycle monitor: compare settled outputs with the model, count strobes.
    always @(negedge clk) begin
        cycles++;
        if (load) load_seen++;
        if (rst_n && settle >= SETTLE) begin
            chk(seg == exp_seg, "seg vs model", seg, exp_seg);
            chk(load == 1'b0, "load idle", {{(NOUT-1){1'b0}}, load}, '0);
        end
        settle++;
        if (cycles > WDOG) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, WDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input bit d);
        sdat = d;
        tick(HALF);
        sclk = 1'b1; model_rise(d); settle = 0;
        tick(HALF);
        sclk = 1'b0; model_fall(); settle = 0;
    endtask

    task automatic frame(input logic [NOUT-1:0] v);
        sbit(1'b1);
        for (int j = 0; j < NOUT; j++) sbit(v[j]);
        tick(SETTLE + 2);
    endtask

    task automatic set_en(input bit e);
        sen = e; settle = 0;
        tick(HALF);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; q.delete(); exp_seg = '0; settle = 0;
        tick(3);
        rst_n = 1'b1;
        tick(SETTLE + 1);
    endtask

    task automatic chk_loads();
        chk(load_seen == load_exp, "load count", NOUT'(load_seen), NOUT'(load_exp));
    endtask

    localparam logic [NOUT-1:0] PAT_A = 35'h5_5555_5555;
    localparam logic [NOUT-1:0] PAT_B = 35'h4_F0F0_0F3C;
    localparam logic [NOUT-1:0] PAT_C = 35'h0_0000_0001;
    localparam logic [NOUT-1:0] PAT_D = 35'h7_FFFF_FFFE;

    initial begin
        // R1: reset state
        req = "R1";
        tick(4);
        chk(seg == '0, "reset seg", seg, '0);
        rst_n = 1'b1;
        set_en(1'b1);
        tick(SETTLE);
        chk(seg == '0, "post-reset seg", seg, '0);

        // R2: full frame, bit k to output k-1
        req = "R2";
        frame(PAT_A);
        chk(seg == PAT_A, "frame A", seg, PAT_A);
        // R3: exactly one strobe per frame
        req = "R3";
        chk(load_seen == 1, "one strobe", NOUT'(load_seen), NOUT'(1));

        // R5: back-to-back frames
        req = "R5";
        frame(PAT_B);
        chk(seg == PAT_B, "back-to-back B", seg, PAT_B);
        frame(PAT_C);
        chk(seg == PAT_C, "back-to-back C", seg, PAT_C);
        chk_loads();

        // R8: identical reload keeps outputs
        req = "R8";
        frame(PAT_C);
        chk(seg == PAT_C, "identical reload", seg, PAT_C);
        chk_loads();

        // R4: partial frame leaves outputs and loads nothing
        req = "R4";
        sbit(1'b1);
        for (int j = 0; j < 19; j++) sbit(PAT_D[j]);
        tick(SETTLE + 2);
        chk(seg == PAT_C, "partial no load", seg, PAT_C);
        chk_loads();

        // R9: reset mid-frame then full frame
        req = "R9";
        do_reset();
        chk(seg == '0, "reset after partial", seg, '0);
        set_en(1'b1);
        load_seen = 0; load_exp = 0;
        frame(PAT_D);
        chk(seg == PAT_D, "frame after reset", seg, PAT_D);
        chk_loads();

        // R6: enable pause in the middle of a frame
        req = "R6";
        sbit(1'b1);
        for (int j = 0; j < 10; j++) sbit(PAT_B[j]);
        set_en(1'b0);
        for (int j = 0; j < 5; j++) sbit(1'b1);
        tick(SETTLE);
        chk(seg == PAT_D, "paused no change", seg, PAT_D);
        set_en(1'b1);
        for (int j = 10; j < NOUT; j++) sbit(PAT_B[j]);
        tick(SETTLE + 2);
        chk(seg == PAT_B, "split frame", seg, PAT_B);
        chk_loads();

        // R7: leading zero clocks before start bit
        req = "R7";
        for (int j = 0; j < 7; j++) sbit(1'b0);
        frame(PAT_A);
        chk(seg == PAT_A, "leading zeros", seg, PAT_A);
        chk_loads();

        tick(10);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule